// File: doc/BRIEF.md
# Four-Channel Sample Mixer with Channel and Master Volume

This block takes four signed 16-bit sample streams that share one sample beat, scales each by its own channel volume, adds the four results in a wide accumulator, scales the sum by a master volume and clips it to the signed 16-bit range. Channel volume has 128 codes and master volume has 16 codes. In both, code 0 is silence and the top code passes the signal unchanged.

A fade mode can be switched on. While it is on, writing a channel volume does not change the gain at once. The value written becomes the goal, and the working gain moves one code toward it with each accepted sample. Settings are written through a plain write strobe with an address and data. The sample path uses valid/ready handshakes on both sides. The whole two-stage pipeline advances only while the output slot is empty or being taken, so back-pressure from the consumer reaches the producer in the same cycle.

Top module: `mix4_vol`

## Requirements
- R1: After a synchronous reset: o_valid is 0, o_data is 0, in_ready is 1, every channel code is 127, the master code is 15 and fade is off.
- R2: A channel with code c has gain g = c/128 for c < 127 and g = 1 for c = 127. Its scaled sample is floor(s*g). Code 0 gives 0.
- R3: The four scaled samples are added without overflow in an accumulator wider than 16 bits.
- R4: Master code m has gain m/16 for m < 15 and 1 for m = 15. The output is floor(sum*gain), clipped to the range -32768..32767.
- R5: in_ready equals (!o_valid || o_ready). A sample is taken when in_valid and in_ready are both high. While o_valid is high and o_ready is low, o_valid and o_data hold.
- R6: A sample taken at one clock edge appears with o_valid high after the second edge that follows, provided the pipeline is not stalled.
- R7: Settings address map: addresses 0 to 3 are channel codes (cfg_wdata[6:0]), 4 is the master code (cfg_wdata[3:0]) and 5 is fade enable (cfg_wdata[0]). Writes to 6 and 7 change nothing.
- R8: With fade off, a channel or master write applies to samples taken after the write cycle. A sample taken in the write cycle uses the old value.
- R9: With fade on, a channel write sets only the goal. Each taken sample uses the current working gain, and the working gain then moves one code toward the goal.
- R10: A channel write during a ramp changes the goal and the ramp continues from the present working gain. If a write and a taken sample fall in the same cycle, the step goes toward the newly written value.
- R11: When fade is off, a working gain that differs from its goal takes the goal value in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample set is valid |
| in_ready | output | 1 | Block can take a sample set |
| in_samples | input | 64 | Four signed samples, channel k in bits [16k+15:16k] |
| cfg_we | input | 1 | Settings write strobe |
| cfg_addr | input | 3 | Settings address |
| cfg_wdata | input | 7 | Settings write data |
| o_valid | output | 1 | Output sample is valid |
| o_ready | input | 1 | Consumer takes the output sample |
| o_data | output | 16 | Mixed, scaled and clipped sample |

## Verification
A volume write and an accepted sample can land on the same clock edge. The sample must then use the old gain. With fade on, the ramp step taken on that edge must go toward the newly written value. The bench provokes this collision on purpose: it writes during acceptance with fade off, and again mid-ramp with fade on. It judges the results against hand-computed outputs, and also compares the outputs with a behavioural model on every clock during a long random phase that mixes writes, stalls and samples.

// File: rtl/mix4_pkg.sv
package mix4_pkg;
  localparam int CH_N   = 4;
  localparam int SMP_W  = 16;
  localparam int CV_W   = 7;
  localparam int MV_W   = 4;
endpackage

// File: rtl/mix4_gain_ctrl.sv
module mix4_gain_ctrl #(
  parameter int CV_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fade_en,
  input  logic            wr,
  input  logic [CV_W-1:0] wdata,
  input  logic            step,
  output logic [CV_W-1:0] cur,
  output logic [CV_W-1:0] tgt
);
  localparam logic [CV_W-1:0] TOP = '1;
  logic [CV_W-1:0] aim;
  logic [CV_W-1:0] ramp;

  assign aim  = wr ? wdata : tgt;
  assign ramp = (cur < aim) ? cur + 1'b1 : cur - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= TOP;
      tgt <= TOP;
    end else begin
      if (wr) tgt <= wdata;
      if (!fade_en)
        cur <= aim;
      else if (step && (cur != aim))
        cur <= ramp;
    end
  end
endmodule

// File: rtl/mix4_sum_stage.sv
module mix4_sum_stage #(
  parameter int N_CH  = 4,
  parameter int SMP_W = 16,
  parameter int CV_W  = 7,
  parameter int MV_W  = 4,
  parameter int ACC_W = 18
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      vin,
  input  logic [N_CH*SMP_W-1:0]     samples,
  input  logic [N_CH*CV_W-1:0]      codes,
  input  logic [MV_W-1:0]           mcode_in,
  output logic                      vout,
  output logic signed [ACC_W-1:0]   sum_out,
  output logic [MV_W-1:0]           mcode_out
);
  localparam int PW = SMP_W + CV_W + 2;
  logic signed [SMP_W-1:0] scaled [N_CH];
  logic signed [ACC_W-1:0] acc;

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    logic [CV_W-1:0]       code;
    logic [CV_W:0]         gain;
    logic signed [PW-1:0]  prod;
    logic signed [PW-1:0]  shf;
    assign code = codes[k*CV_W +: CV_W];
    assign gain = (code == {CV_W{1'b1}}) ? (CV_W+1)'(1 << CV_W) : {1'b0, code};
    assign prod = $signed(samples[k*SMP_W +: SMP_W]) * $signed({1'b0, gain});
    assign shf  = prod >>> CV_W;
    assign scaled[k] = shf[SMP_W-1:0];
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < N_CH; k++)
      acc = acc + {{(ACC_W-SMP_W){scaled[k][SMP_W-1]}}, scaled[k]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vout      <= 1'b0;
      sum_out   <= '0;
      mcode_out <= '0;
    end else if (en) begin
      vout      <= vin;
      sum_out   <= acc;
      mcode_out <= mcode_in;
    end
  end
endmodule

// File: rtl/mix4_master_stage.sv
module mix4_master_stage #(
  parameter int ACC_W = 18,
  parameter int MV_W  = 4,
  parameter int SMP_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     vin,
  input  logic signed [ACC_W-1:0]  sum,
  input  logic [MV_W-1:0]          mcode,
  output logic                     vout,
  output logic [SMP_W-1:0]         dout
);
  localparam int PW = ACC_W + MV_W + 2;
  localparam logic signed [PW-1:0] SMAX = PW'((64'sd1 <<< (SMP_W-1)) - 1);
  localparam logic signed [PW-1:0] SMIN = -SMAX - 1;

  logic [MV_W:0]          gain;
  logic signed [PW-1:0]   prod;
  logic signed [PW-1:0]   shf;
  logic [SMP_W-1:0]       clip;

  assign gain = (mcode == {MV_W{1'b1}}) ? (MV_W+1)'(1 << MV_W) : {1'b0, mcode};
  assign prod = sum * $signed({1'b0, gain});
  assign shf  = prod >>> MV_W;

  always_comb begin
    if (shf > SMAX)      clip = SMAX[SMP_W-1:0];
    else if (shf < SMIN) clip = SMIN[SMP_W-1:0];
    else                 clip = shf[SMP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vout <= 1'b0;
      dout <= '0;
    end else if (en) begin
      vout <= vin;
      dout <= clip;
    end
  end
endmodule

// File: rtl/mix4_vol.sv
module mix4_vol #(
  parameter int N_CH  = mix4_pkg::CH_N,
  parameter int SMP_W = mix4_pkg::SMP_W,
  parameter int CV_W  = mix4_pkg::CV_W,
  parameter int MV_W  = mix4_pkg::MV_W,
  parameter int AW    = $clog2(N_CH + 2)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [N_CH*SMP_W-1:0] in_samples,
  input  logic                  cfg_we,
  input  logic [AW-1:0]         cfg_addr,
  input  logic [CV_W-1:0]       cfg_wdata,
  output logic                  o_valid,
  input  logic                  o_ready,
  output logic [SMP_W-1:0]      o_data
);
  localparam int ACC_W = SMP_W + $clog2(N_CH);
  localparam logic [AW-1:0] A_MST  = AW'(N_CH);
  localparam logic [AW-1:0] A_FADE = AW'(N_CH + 1);

  logic                    adv;
  logic                    take;
  logic                    fade_q;
  logic [MV_W-1:0]         mst_q;
  logic [N_CH*CV_W-1:0]    cur_flat;
  logic [N_CH*CV_W-1:0]    tgt_flat;
  logic                    s1_v;
  logic signed [ACC_W-1:0] s1_sum;
  logic [MV_W-1:0]         s1_m;

  assign adv      = !o_valid || o_ready;
  assign in_ready = adv;
  assign take     = in_valid && adv;

  always_ff @(posedge clk) begin
    if (rst) begin
      fade_q <= 1'b0;
      mst_q  <= '1;
    end else if (cfg_we) begin
      if (cfg_addr == A_MST)  mst_q  <= cfg_wdata[MV_W-1:0];
      if (cfg_addr == A_FADE) fade_q <= cfg_wdata[0];
    end
  end

  for (genvar k = 0; k < N_CH; k++) begin : g_gain
    mix4_gain_ctrl #(.CV_W(CV_W)) u_gain (
      .clk     (clk),
      .rst     (rst),
      .fade_en (fade_q),
      .wr      (cfg_we && (cfg_addr == AW'(k))),
      .wdata   (cfg_wdata),
      .step    (take),
      .cur     (cur_flat[k*CV_W +: CV_W]),
      .tgt     (tgt_flat[k*CV_W +: CV_W])
    );
  end

  mix4_sum_stage #(
    .N_CH(N_CH), .SMP_W(SMP_W), .CV_W(CV_W), .MV_W(MV_W), .ACC_W(ACC_W)
  ) u_sum (
    .clk       (clk),
    .rst       (rst),
    .en        (adv),
    .vin       (in_valid),
    .samples   (in_samples),
    .codes     (cur_flat),
    .mcode_in  (mst_q),
    .vout      (s1_v),
    .sum_out   (s1_sum),
    .mcode_out (s1_m)
  );

  mix4_master_stage #(
    .ACC_W(ACC_W), .MV_W(MV_W), .SMP_W(SMP_W)
  ) u_mst (
    .clk   (clk),
    .rst   (rst),
    .en    (adv),
    .vin   (s1_v),
    .sum   (s1_sum),
    .mcode (s1_m),
    .vout  (o_valid),
    .dout  (o_data)
  );
endmodule

// File: rtl/mix4_vol_chk.sv
module mix4_vol_chk #(
  parameter int N_CH  = 4,
  parameter int SMP_W = 16,
  parameter int CV_W  = 7,
  parameter int AW    = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 o_valid,
  input logic                 o_ready,
  input logic [SMP_W-1:0]     o_data,
  input logic                 cfg_we,
  input logic [AW-1:0]        cfg_addr,
  input logic                 fade_q,
  input logic [N_CH*CV_W-1:0] cur_flat,
  input logic [N_CH*CV_W-1:0] tgt_flat
);
  function automatic logic near(input logic [CV_W-1:0] a, input logic [CV_W-1:0] b);
    return (a == b) || (a == b + 1'b1) || (b == a + 1'b1);
  endfunction

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    o_valid && !o_ready |=> o_valid); // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    o_valid && !o_ready |=> $stable(o_data)); // R5

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(in_valid && in_ready) && in_ready |=> o_valid); // R6

  for (genvar k = 0; k < N_CH; k++) begin : g_ck
    AST_FADE_STEP: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) && $past(fade_q) |-> near(cur_flat[k*CV_W +: CV_W], $past(cur_flat[k*CV_W +: CV_W]))); // R9

    AST_FADE_SNAP: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) && $past(!fade_q && !(cfg_we && cfg_addr == AW'(k)))
      |-> cur_flat[k*CV_W +: CV_W] == $past(tgt_flat[k*CV_W +: CV_W])); // R11
  end
endmodule

bind mix4_vol mix4_vol_chk #(.N_CH(N_CH), .SMP_W(SMP_W), .CV_W(CV_W), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .o_valid  (o_valid),
  .o_ready  (o_ready),
  .o_data   (o_data),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .fade_q   (fade_q),
  .cur_flat (cur_flat),
  .tgt_flat (tgt_flat)
);

// File: tb/test_mix4_vol.sv
module test_mix4_vol;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_samples;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [6:0]  cfg_wdata;
  logic        o_valid;
  logic        o_ready;
  logic [15:0] o_data;

  int total = 0;
  int bad   = 0;
  string req = "R1";

  integer m_cur [4];
  integer m_tgt [4];
  integer m_mst, m_fade, m1_v, m1_sum, m1_m, mo_v, mo_d;

  always #(CLK_P/2) clk = ~clk;

  mix4_vol i_mix4_vol (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_samples(in_samples), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data)
  );

  function automatic integer cg(input integer c);
    return (c == 127) ? 128 : c;
  endfunction
  function automatic integer mg(input integer m);
    return (m == 15) ? 16 : m;
  endfunction
  function automatic integer toward(input integer c, input integer t);
    return (c < t) ? c + 1 : c - 1;
  endfunction

  task automatic chk(input string r, input integer act, input integer exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 4; c++) begin m_cur[c] = 127; m_tgt[c] = 127; end
    m_mst = 15; m_fade = 0; m1_v = 0; m1_sum = 0; m1_m = 0; mo_v = 0; mo_d = 0;
  endtask

  // one clock: predict, step, compare
  task automatic cyc();
    integer adv, acc, t, s, d;
    integer n_cur [4];
    integer n_tgt [4];
    integer n_mst, n_fade, n1_v, n1_sum, n1_m, no_v, no_d;
    adv = (!mo_v || o_ready) ? 1 : 0;
    acc = (in_valid && adv) ? 1 : 0;
    n1_v = m1_v; n1_sum = m1_sum; n1_m = m1_m; no_v = mo_v; no_d = mo_d;
    if (adv) begin
      no_v = m1_v;
      t = (m1_sum * mg(m1_m)) >>> 4;
      if (t > 32767) t = 32767;
      if (t < -32768) t = -32768;
      no_d = t;
      n1_v = in_valid;
      n1_sum = 0;
      for (int c = 0; c < 4; c++) begin
        s = $signed(in_samples[c*16 +: 16]);
        n1_sum = n1_sum + ((s * cg(m_cur[c])) >>> 7);
      end
      n1_m = m_mst;
    end
    n_mst = m_mst; n_fade = m_fade;
    d = cfg_wdata;
    for (int c = 0; c < 4; c++) begin
      n_cur[c] = m_cur[c]; n_tgt[c] = m_tgt[c];
      if (cfg_we && cfg_addr == c) begin
        n_tgt[c] = d;
        if (!m_fade) n_cur[c] = d;
        else if (acc && m_cur[c] != d) n_cur[c] = toward(m_cur[c], d);
      end else if (!m_fade) n_cur[c] = m_tgt[c];
      else if (acc && m_cur[c] != m_tgt[c]) n_cur[c] = toward(m_cur[c], m_tgt[c]);
    end
    if (cfg_we && cfg_addr == 4) n_mst = d & 15;
    if (cfg_we && cfg_addr == 5) n_fade = d & 1;
    @(posedge clk);
    for (int c = 0; c < 4; c++) begin m_cur[c] = n_cur[c]; m_tgt[c] = n_tgt[c]; end
    m_mst = n_mst; m_fade = n_fade; m1_v = n1_v; m1_sum = n1_sum; m1_m = n1_m;
    mo_v = no_v; mo_d = no_d;
    @(negedge clk);
    chk({req, " valid"}, o_valid, mo_v);
    chk({req, " ready"}, in_ready, (!mo_v || o_ready) ? 1 : 0);
    if (mo_v) chk({req, " data"}, $signed(o_data), mo_d);
  endtask

  task automatic setsmp(input integer a, input integer b, input integer c, input integer e);
    in_samples = {16'(e), 16'(c), 16'(b), 16'(a)};
  endtask

  task automatic wr(input integer a, input integer d);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 7'(d);
    cyc();
    cfg_we = 1'b0;
  endtask

  // send one sample (optionally with a write in the same cycle) and check result two edges later
  task automatic sendget(input integer a, input integer b, input integer c, input integer e,
                         input integer exp, input string r);
    in_valid = 1'b1; setsmp(a, b, c, e);
    cyc();
    in_valid = 1'b0; cfg_we = 1'b0;
    chk({r, " latency first edge"}, o_valid, 0);
    cyc();
    chk({r, " latency second edge"}, o_valid, 1);
    chk(r, $signed(o_data), exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_samples = '0; cfg_we = 1'b0; cfg_addr = '0;
    cfg_wdata = '0; o_ready = 1'b1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 o_valid", o_valid, 0);
    chk("R1 o_data", o_data, 0);
    chk("R1 in_ready", in_ready, 1);
    sendget(100, 0, 0, 0, 100, "R1 unity defaults");

    req = "R3";
    sendget(1000, 2000, -500, 3, 2503, "R3 sum");
    sendget(-7, 11, -13, 17, 8, "R3 mixed signs");

    req = "R2";
    wr(0, 64);
    sendget(1000, 0, 0, 0, 500, "R2 half code");
    sendget(-1, 0, 0, 0, -1, "R2 floor negative");
    wr(0, 0);
    sendget(1000, 0, 0, 0, 0, "R2 mute");
    wr(0, 127);

    req = "R8";
    cfg_we = 1'b1; cfg_addr = 3'd1; cfg_wdata = 7'd0;
    sendget(0, 1000, 0, 0, 1000, "R8 same-cycle write uses old");
    sendget(0, 1000, 0, 0, 0, "R8 next sample uses new");
    wr(1, 127);

    req = "R4";
    wr(4, 8);
    sendget(1000, 1000, 0, 0, 1000, "R4 master half");
    wr(4, 0);
    sendget(1000, 1000, 0, 0, 0, "R4 master mute");
    wr(4, 15);
    sendget(32767, 32767, 32767, 32767, 32767, "R4 clip high");
    sendget(-32768, -32768, -32768, -32768, -32768, "R4 clip low");

    req = "R7";
    wr(6, 0); wr(7, 0);
    sendget(100, 100, 0, 0, 200, "R7 unmapped writes ignored");
    wr(5, 2);
    wr(2, 64);
    sendget(0, 0, 1280, 0, 640, "R7 fade bit0 only");
    wr(2, 127);

    req = "R5";
    o_ready = 1'b0;
    in_valid = 1'b1; setsmp(300, 0, 0, 0);
    cyc(); cyc();
    in_valid = 1'b0;
    chk("R5 held valid", o_valid, 1);
    chk("R5 ready low", in_ready, 0);
    repeat (4) cyc();
    chk("R5 data held", $signed(o_data), 300);
    o_ready = 1'b1;
    repeat (3) cyc();

    req = "R9";
    wr(5, 1);
    wr(0, 64);
    sendget(12800, 0, 0, 0, 12800, "R9 first sample pre-step gain");
    sendget(12800, 0, 0, 0, 12600, "R9 one step down");
    sendget(12800, 0, 0, 0, 12500, "R9 second step");

    req = "R10";
    cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 7'd127;
    sendget(12800, 0, 0, 0, 12400, "R10 write with sample");
    sendget(12800, 0, 0, 0, 12500, "R10 ramp reversed from current");

    req = "R11";
    wr(0, 10);
    sendget(12800, 0, 0, 0, 12600, "R11 ramp running");
    wr(5, 0);
    cyc();
    sendget(12800, 0, 0, 0, 1000, "R11 snap to goal");
    wr(0, 127);

    req = "R6";
    for (int i = 0; i < 6; i++) begin
      in_valid = 1'b1; setsmp(i * 10, 0, 0, 0);
      cyc();
    end
    in_valid = 1'b0;
    cyc(); cyc();

    req = "R5 random";
    for (int i = 0; i < 4000; i++) begin
      in_valid = 1'($urandom_range(0, 1));
      o_ready  = ($urandom_range(0, 3) != 0);
      in_samples = {$urandom(), $urandom()};
      cfg_we = ($urandom_range(0, 7) == 0);
      cfg_addr = 3'($urandom_range(0, 7));
      cfg_wdata = ($urandom_range(0, 3) == 0) ? 7'($urandom_range(120, 127)) : 7'($urandom());
      cyc();
    end
    cfg_we = 1'b0; in_valid = 1'b0; o_ready = 1'b1;
    repeat (4) cyc();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule